// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a free-running periodic timer for a processor subsystem. A 24-bit down counter, clocked by the bus clock, counts from a programmed reload value down to zero and then reloads itself. Each pass from one to zero marks the end of one period. It sets a sticky status flag and, when enabled, raises a one-cycle interrupt request. With a reload value of n, one period lasts n+1 bus clocks.

Software reaches the block through three word registers on a simple single-cycle bus. The control word holds the run enable, the interrupt enable, the clock-source select and the sticky period flag. The reload word holds the value that is loaded on each wrap. The current word holds the live count. Any write to the current word zeroes the count, whatever the data, so software can restart a period cleanly. Reading the control word consumes the period flag. Only the core-clock source is implemented: with the source bit cleared, the counter does not move.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word, the reload word, the current word and the interrupt request all read as zero.
- R2: Byte offsets are 0x0 for control, 0x4 for reload and 0x8 for current; unmapped offsets read zero. Reload keeps only its low 24 bits and reads zero in bits 31..24. Control reads back bits 0 (run enable), 1 (interrupt enable), 2 (clock source) and 16 (period flag); all other control bits read zero.
- R3: While bits 0 and 2 of control are both 1, the count drops by one each clock. When the count is zero, the next clock loads the reload value instead.
- R4: After the count is cleared and counting starts, the count after k clocks is 0 for k = 0 and n - ((k-1) mod (n+1)) for k ≥ 1, where n is the reload value. The period is therefore n+1 clocks.
- R5: A write of any data to the current word sets the count to zero and clears the period flag.
- R6: The period flag (control bit 16) is set on every step of the count from 1 to 0. It stays set after counting stops, until it is consumed.
- R7: A read of the control word returns the flag and clears it, so an immediate second read shows it clear. A flag set in the same clock as the read is kept.
- R8: The interrupt request is high for exactly one clock after each step from 1 to 0, and only while control bit 1 is set.
- R9: With control bit 2 at 0, the count does not move even when bit 0 is 1 (external source unsupported).
- R10: With reload 0 and the count at zero, the count stays zero: no flag is set and no interrupt is raised.
- R11: With control bit 0 at 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also the counting clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read, qualified by busSel |
| busAddr | input | 4 | Byte offset of the accessed word |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, valid in the cycle busSel is high for a read |
| irqPulse | output | 1 | One-clock interrupt request at each period end |

## Verification
The assertions assume that busSel, busWr and busAddr are known after reset and that each access lasts a single clock. They also assume that a read's side effect on the flag happens at the clock edge that ends the access. The bench therefore drives every access on the falling edge and holds it for exactly one rising edge. It then drops busSel before the next access and samples read data before that edge. Between accesses the bus is idle, so the counter's behaviour comes from the programmed values alone.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_IRQEN_BIT = 1;
  localparam int CTRL_SRC_BIT   = 2;
  localparam int CTRL_FLAG_BIT  = 16;

  typedef struct packed {
    logic run;     // counting allowed this clock
    logic irqEn;   // interrupt request gate
    logic clrCur;  // write to current word
    logic rdCtrl;  // read of control word
  } tickStrobes_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  input  logic [CNT_W-1:0]  curVal,
  input  logic              countFlag,
  output tickStrobes_t      strb,
  output logic [CNT_W-1:0]  reloadVal
);
  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_RELOAD = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CUR    = ADDR_W'(8);

  logic selCtrl, selReload, selCur;
  logic enReg, irqEnReg, srcReg;
  logic [DATA_W-1:0] ctrlWord;

  assign selCtrl   = (busAddr == OFS_CTRL);
  assign selReload = (busAddr == OFS_RELOAD);
  assign selCur    = (busAddr == OFS_CUR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      irqEnReg  <= 1'b0;
      srcReg    <= 1'b0;
      reloadVal <= '0;
    end else if (busSel && busWr) begin
      if (selCtrl) begin
        enReg    <= busWData[CTRL_EN_BIT];
        irqEnReg <= busWData[CTRL_IRQEN_BIT];
        srcReg   <= busWData[CTRL_SRC_BIT];
      end
      if (selReload) reloadVal <= busWData[CNT_W-1:0];
    end
  end

  always_comb begin
    strb.run    = enReg & srcReg;
    strb.irqEn  = irqEnReg;
    strb.clrCur = busSel & busWr & selCur;
    strb.rdCtrl = busSel & ~busWr & selCtrl;
  end

  always_comb begin
    ctrlWord                 = '0;
    ctrlWord[CTRL_EN_BIT]    = enReg;
    ctrlWord[CTRL_IRQEN_BIT] = irqEnReg;
    ctrlWord[CTRL_SRC_BIT]   = srcReg;
    ctrlWord[CTRL_FLAG_BIT]  = countFlag;
  end

  always_comb begin
    busRData = '0;
    if (busSel && !busWr) begin
      if (selCtrl)        busRData = ctrlWord;
      else if (selReload) busRData = DATA_W'(reloadVal);
      else if (selCur)    busRData = DATA_W'(curVal);
    end
  end

  assert_reload_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && selReload) |=> (reloadVal == $past(busWData[CNT_W-1:0])));

  assert_reload_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && (selReload || selCur)) |-> (busRData[DATA_W-1:CNT_W] == '0));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr && selCtrl) |=> $stable(strb.run) && $stable(strb.irqEn));
endmodule

// File: rtl/tick_dp.sv
module tick_dp
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickStrobes_t     strb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] curVal,
  output logic             countFlag,
  output logic             irqPulse
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic atZero, wrapNow;

  assign atZero  = (curVal == '0);
  assign wrapNow = strb.run && (curVal == CNT_ONE) && !strb.clrCur;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curVal    <= '0;
      countFlag <= 1'b0;
      irqPulse  <= 1'b0;
    end else begin
      if (strb.clrCur)  curVal <= '0;
      else if (strb.run) curVal <= atZero ? reloadVal : curVal - CNT_ONE;

      if (strb.clrCur)      countFlag <= 1'b0;
      else if (wrapNow)     countFlag <= 1'b1;
      else if (strb.rdCtrl) countFlag <= 1'b0;

      irqPulse <= wrapNow && strb.irqEn;
    end
  end

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.clrCur && !atZero) |=> (curVal == $past(curVal) - CNT_ONE));

  assert_reload_on_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.clrCur && atZero) |=> (curVal == $past(reloadVal)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCur |=> (curVal == '0 && !countFlag));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clrCur) |=> $stable(curVal));

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(strb.irqEn) && countFlag && curVal == '0));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              irqPulse
);
  tickStrobes_t     strb;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] curVal;
  logic             countFlag;

  tick_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .curVal(curVal),
    .countFlag(countFlag), .strb(strb), .reloadVal(reloadVal)
  );

  tick_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadVal(reloadVal),
    .curVal(curVal), .countFlag(countFlag), .irqPulse(irqPulse)
  );
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        irqPulse;

  int checkCnt = 0;
  int failCnt  = 0;
  int irqCount = 0;
  int irqRun   = 0;
  int irqMaxRun = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CUR = 4'h8, A_BAD = 4'hC;
  localparam int NVEC = 10;
  localparam logic [23:0] VEC_RLD  [NVEC] = '{24'd5, 24'd5, 24'd5, 24'd5, 24'd5,
                                              24'd1, 24'd0, 24'hFFFFFF, 24'd3, 24'd100};
  localparam int          VEC_WAIT [NVEC] = '{0, 1, 6, 7, 13, 4, 5, 3, 20, 50};

  always #2.5 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .irqPulse(irqPulse)
  );

  always @(negedge clk) begin
    if (irqPulse) begin
      irqCount++;
      irqRun++;
      if (irqRun > irqMaxRun) irqMaxRun = irqRun;
    end else begin
      irqRun = 0;
    end
  end

  function automatic logic [31:0] expCur(longint n, int k);
    if (k == 0) return 32'd0;
    return 32'(n - ((longint'(k) - 1) % (n + 1)));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(logic [3:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRData;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int irqBase;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(A_CTRL, rd); check("R1 ctrl", rd, 32'h0);
    busRead(A_RLD, rd);  check("R1 reload", rd, 32'h0);
    busRead(A_CUR, rd);  check("R1 current", rd, 32'h0);
    check("R1 irq", {31'd0, irqPulse}, 32'h0);

    // R2 readback and reserved bits
    busWrite(A_RLD, 32'hFFFF_FFFF);
    busRead(A_RLD, rd);  check("R2 reload upper", rd, 32'h00FF_FFFF);
    busWrite(A_CTRL, 32'hFFFF_FFFF);
    busRead(A_CTRL, rd); check("R2 ctrl reserved", rd, 32'h0000_0007);
    busWrite(A_CTRL, 32'h0);
    busRead(A_BAD, rd);  check("R2 unmapped", rd, 32'h0);

    // R3 R4 table walk
    for (int i = 0; i < NVEC; i++) begin
      busWrite(A_CTRL, 32'h0);
      busWrite(A_RLD, {8'h0, VEC_RLD[i]});
      busWrite(A_CUR, 32'h0);
      busWrite(A_CTRL, 32'h5);
      idle(VEC_WAIT[i]);
      busRead(A_CUR, rd);
      check($sformatf("R4 vec%0d", i), rd, expCur(longint'(VEC_RLD[i]), VEC_WAIT[i]));
    end

    // R8 R6 irq pulses and sticky flag
    busWrite(A_CTRL, 32'h0);
    busWrite(A_RLD, 32'd3);
    busWrite(A_CUR, 32'h0);
    irqBase = irqCount; irqMaxRun = 0;
    busWrite(A_CTRL, 32'h7);
    idle(42);
    check("R8 pulse count", 32'(irqCount - irqBase), 32'd10);
    check("R8 pulse width", 32'(irqMaxRun), 32'd1);
    busWrite(A_CTRL, 32'h0);
    busRead(A_CTRL, rd); check("R6 sticky flag", rd, 32'h0001_0000);
    busRead(A_CTRL, rd); check("R7 read clears", rd, 32'h0);

    // R5 clear on any write
    busWrite(A_RLD, 32'd2);
    busWrite(A_CUR, 32'h0);
    busWrite(A_CTRL, 32'h5);
    idle(10);
    busWrite(A_CTRL, 32'h0);
    busWrite(A_CUR, 32'hDEAD_BEEF);
    busRead(A_CUR, rd);  check("R5 current cleared", rd, 32'h0);
    busRead(A_CTRL, rd); check("R5 flag cleared", rd, 32'h0);

    // R8 no irq without interrupt enable
    irqBase = irqCount;
    busWrite(A_CTRL, 32'h5);
    idle(20);
    busWrite(A_CTRL, 32'h0);
    check("R8 gated irq", 32'(irqCount - irqBase), 32'd0);
    busRead(A_CTRL, rd); check("R6 flag without irq", rd, 32'h0001_0000);

    // R9 clock source 0 does not count
    busWrite(A_RLD, 32'd5);
    busWrite(A_CUR, 32'h0);
    busWrite(A_CTRL, 32'h1);
    idle(10);
    busRead(A_CUR, rd);  check("R9 no count", rd, 32'h0);
    busRead(A_CTRL, rd); check("R9 ctrl no flag", rd, 32'h1);

    // R11 enable off holds
    busWrite(A_CTRL, 32'h0);
    busWrite(A_RLD, 32'd10);
    busWrite(A_CUR, 32'h0);
    busWrite(A_CTRL, 32'h5);
    idle(4);
    busWrite(A_CTRL, 32'h0);
    idle(5);
    busRead(A_CUR, rd);  check("R11 hold", rd, 32'd6);

    // R10 reload zero never flags
    busWrite(A_RLD, 32'd0);
    busWrite(A_CUR, 32'h0);
    irqBase = irqCount;
    busWrite(A_CTRL, 32'h7);
    idle(30);
    busRead(A_CTRL, rd); check("R10 no flag", rd, 32'h7);
    check("R10 no irq", 32'(irqCount - irqBase), 32'd0);
    busRead(A_CUR, rd);  check("R10 stays zero", rd, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule